// File: doc/BRIEF.md
# Rotational-Interleaving Cluster Bank Locator

This block picks the tile whose cache bank should be asked for a line in a tiled, mesh-connected last-level cache. Instruction lines are replicated across overlapping four-tile clusters. Each tile carries a two-bit rotational id that rises by one per column and by two per row, both modulo 4. The block subtracts two address bits from the requester's rotational id. The sign and size of that difference point to the requester's own tile or to one of its right, left or lower neighbours. The mesh wraps at its edges, so the rightmost column's right neighbour is column 0, and the same holds for the other directions.

When the cluster lookup has already missed, the request is flagged as a fallback. The block then returns a statically mapped home tile taken straight from the address, and raises a remote flag. Private data always goes to the requester's own tile. Shared data always goes to the statically mapped tile. The decision is combinational and is captured in one output register stage, so a result appears one clock after its request.

Top module: `rinl_bank_locator`

## Requirements
- R1: `rsp_valid_o` is high in exactly the cycle after each cycle in which `req_valid_i` is high, and low otherwise.
- R2: In a cycle after `req_valid_i` was low, `dst_x_o`, `dst_y_o` and `remote_o` keep their previous values.
- R3: While `rst_ni` is low, every output is zero.
- R4: For an instruction request (`req_kind_i` = 0) with `req_miss_i` low, let sel = `req_addr_i[SEL_LSB+1:SEL_LSB]`. When rid − sel equals 0, the destination is the requester's own tile and `remote_o` is 0.
- R5: For that case, when rid − sel is −1 or +3, the destination is column x+1 modulo MESH_W in the same row. `remote_o` is 0.
- R6: For that case, when rid − sel is +1 or −3, the destination is column x−1 modulo MESH_W in the same row. `remote_o` is 0.
- R7: For that case, when rid − sel is ±2, the destination is row y+1 modulo MESH_H in the same column. `remote_o` is 0.
- R8: An instruction request with `req_miss_i` high goes to the static home tile and sets `remote_o` to 1. The static home tile has column `req_addr_i[SEL_LSB+1:SEL_LSB]` and row `req_addr_i[SEL_LSB+3:SEL_LSB+2]` for the default 4x4 mesh.
- R9: A private-data request (`req_kind_i` = 1) goes to the requester's own tile with `remote_o` 0, and `req_miss_i` has no effect on it.
- R10: A shared-data request (`req_kind_i` = 2, with code 3 treated the same) goes to the static home tile of R8 with `remote_o` 0, and `req_miss_i` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_x_i | input | X_W | Requester column |
| req_y_i | input | Y_W | Requester row |
| req_rid_i | input | 2 | Requester rotational id |
| req_addr_i | input | ADDR_W | Block address |
| req_kind_i | input | 2 | 0 instruction, 1 private data, 2/3 shared data |
| req_miss_i | input | 1 | Cluster lookup already missed (instruction only) |
| rsp_valid_o | output | 1 | Result valid |
| dst_x_o | output | X_W | Destination column |
| dst_y_o | output | Y_W | Destination row |
| remote_o | output | 1 | Destination is the static fallback for an instruction line |

## Verification
A wrong direction decode shows up as a destination one column or one row off. It appears on the very next cycle after the offending request, because only one register sits between input and output. A broken edge wrap appears only for requesters in the last column or row, and a wrong sign convention appears only for differences of ±3. The bench therefore drives those corners on purpose and compares every cycle against its own model. A capture register that reloads on idle cycles would corrupt the held destination, and this is visible on the first idle cycle.

// File: rtl/rinl_pkg.sv
package rinl_pkg;
  typedef enum logic [1:0] {
    KIND_INSTR  = 2'd0,
    KIND_PRIV   = 2'd1,
    KIND_SHARED = 2'd2,
    KIND_RSVD   = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    DIR_HERE  = 2'd0,
    DIR_LEFT  = 2'd1,
    DIR_DOWN  = 2'd2,
    DIR_RIGHT = 2'd3
  } dir_e;
endpackage

// File: rtl/rinl_ring_dec.sv
module rinl_ring_dec
  import rinl_pkg::*;
(
  input  logic [1:0] rid_i,
  input  logic [1:0] sel_i,
  output dir_e       dir_o
);
  logic signed [2:0] diff;

  assign diff = $signed({1'b0, rid_i}) - $signed({1'b0, sel_i});

  always_comb begin
    unique case (diff)
      3'b000:          dir_o = DIR_HERE;
      3'b111, 3'b011:  dir_o = DIR_RIGHT;  // -1, +3
      3'b001, 3'b101:  dir_o = DIR_LEFT;   // +1, -3
      default:         dir_o = DIR_DOWN;   // +2, -2
    endcase
  end
endmodule

// File: rtl/rinl_mesh_step.sv
module rinl_mesh_step
  import rinl_pkg::*;
#(
  parameter int MESH_W = 4,
  parameter int MESH_H = 4,
  localparam int X_W = (MESH_W > 1) ? $clog2(MESH_W) : 1,
  localparam int Y_W = (MESH_H > 1) ? $clog2(MESH_H) : 1
) (
  input  logic [X_W-1:0] x_i,
  input  logic [Y_W-1:0] y_i,
  input  dir_e           dir_i,
  output logic [X_W-1:0] x_o,
  output logic [Y_W-1:0] y_o
);
  localparam logic [X_W-1:0] X_MAX = X_W'(MESH_W - 1);
  localparam logic [Y_W-1:0] Y_MAX = Y_W'(MESH_H - 1);

  logic [X_W-1:0] x_inc, x_dec;
  logic [Y_W-1:0] y_inc;

  assign x_inc = (x_i == X_MAX) ? '0 : x_i + 1'b1;
  assign x_dec = (x_i == '0) ? X_MAX : x_i - 1'b1;
  assign y_inc = (y_i == Y_MAX) ? '0 : y_i + 1'b1;

  always_comb begin
    x_o = x_i;
    y_o = y_i;
    unique case (dir_i)
      DIR_RIGHT: x_o = x_inc;
      DIR_LEFT:  x_o = x_dec;
      DIR_DOWN:  y_o = y_inc;
      default:   ;
    endcase
  end
endmodule

// File: rtl/rinl_static_map.sv
module rinl_static_map #(
  parameter int ADDR_W  = 32,
  parameter int SEL_LSB = 12,
  parameter int X_W     = 2,
  parameter int Y_W     = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [X_W-1:0]    x_o,
  output logic [Y_W-1:0]    y_o
);
  // low bits pick the column, the next ones the row
  assign x_o = addr_i[SEL_LSB +: X_W];
  assign y_o = addr_i[SEL_LSB + X_W +: Y_W];
endmodule

// File: rtl/rinl_bank_locator.sv
module rinl_bank_locator
  import rinl_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SEL_LSB = 12,
  parameter int MESH_W  = 4,
  parameter int MESH_H  = 4,
  localparam int X_W = (MESH_W > 1) ? $clog2(MESH_W) : 1,
  localparam int Y_W = (MESH_H > 1) ? $clog2(MESH_H) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [X_W-1:0]    req_x_i,
  input  logic [Y_W-1:0]    req_y_i,
  input  logic [1:0]        req_rid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_miss_i,
  output logic              rsp_valid_o,
  output logic [X_W-1:0]    dst_x_o,
  output logic [Y_W-1:0]    dst_y_o,
  output logic              remote_o
);
  logic [1:0]     sel;
  dir_e           dir;
  logic [X_W-1:0] clu_x, home_x, nxt_x;
  logic [Y_W-1:0] clu_y, home_y, nxt_y;
  logic           nxt_remote;
  kind_e          kind;

  assign sel  = req_addr_i[SEL_LSB +: 2];
  assign kind = kind_e'(req_kind_i);

  rinl_ring_dec i_ring_dec (
    .rid_i (req_rid_i),
    .sel_i (sel),
    .dir_o (dir)
  );

  rinl_mesh_step #(
    .MESH_W (MESH_W),
    .MESH_H (MESH_H)
  ) i_mesh_step (
    .x_i   (req_x_i),
    .y_i   (req_y_i),
    .dir_i (dir),
    .x_o   (clu_x),
    .y_o   (clu_y)
  );

  rinl_static_map #(
    .ADDR_W  (ADDR_W),
    .SEL_LSB (SEL_LSB),
    .X_W     (X_W),
    .Y_W     (Y_W)
  ) i_static_map (
    .addr_i (req_addr_i),
    .x_o    (home_x),
    .y_o    (home_y)
  );

  always_comb begin
    nxt_remote = 1'b0;
    unique case (kind)
      KIND_INSTR: begin
        if (req_miss_i) begin
          nxt_x      = home_x;
          nxt_y      = home_y;
          nxt_remote = 1'b1;
        end else begin
          nxt_x = clu_x;
          nxt_y = clu_y;
        end
      end
      KIND_PRIV: begin
        nxt_x = req_x_i;
        nxt_y = req_y_i;
      end
      default: begin
        nxt_x = home_x;
        nxt_y = home_y;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      dst_x_o     <= '0;
      dst_y_o     <= '0;
      remote_o    <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        dst_x_o  <= nxt_x;
        dst_y_o  <= nxt_y;
        remote_o <= nxt_remote;
      end
    end
  end
endmodule

// File: rtl/rinl_bank_locator_chk.sv
module rinl_bank_locator_chk #(
  parameter int ADDR_W  = 32,
  parameter int SEL_LSB = 12,
  parameter int X_W     = 2,
  parameter int Y_W     = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [X_W-1:0]    req_x_i,
  input logic [Y_W-1:0]    req_y_i,
  input logic [1:0]        req_rid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [1:0]        req_kind_i,
  input logic              req_miss_i,
  input logic              rsp_valid_o,
  input logic [X_W-1:0]    dst_x_o,
  input logic [Y_W-1:0]    dst_y_o,
  input logic              remote_o
);
  logic [1:0] sel_c, gap_c;
  assign sel_c = req_addr_i[SEL_LSB +: 2];
  assign gap_c = req_rid_i - sel_c;

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (!rsp_valid_o && dst_x_o == '0 && dst_y_o == '0 && !remote_o)); // R3

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R1

  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R1

  AST_HOLD_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable({dst_x_o, dst_y_o, remote_o})); // R2

  AST_INSTR_HERE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd0 && !req_miss_i && gap_c == 2'd0) |=>
      (dst_x_o == $past(req_x_i) && dst_y_o == $past(req_y_i) && !remote_o)); // R4

  AST_INSTR_DOWN_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd0 && !req_miss_i && gap_c == 2'd2) |=>
      (dst_x_o == $past(req_x_i) && dst_y_o != $past(req_y_i))); // R7

  AST_MISS_REMOTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd0 && req_miss_i) |=>
      (remote_o && dst_x_o == $past(req_addr_i[SEL_LSB +: X_W]))); // R8

  AST_PRIV_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd1) |=>
      (dst_x_o == $past(req_x_i) && dst_y_o == $past(req_y_i) && !remote_o)); // R9

  AST_SHARED_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i[1]) |=>
      (dst_x_o == $past(req_addr_i[SEL_LSB +: X_W]) &&
       dst_y_o == $past(req_addr_i[SEL_LSB + X_W +: Y_W]) && !remote_o)); // R10
endmodule

bind rinl_bank_locator rinl_bank_locator_chk #(
  .ADDR_W  (ADDR_W),
  .SEL_LSB (SEL_LSB),
  .X_W     (X_W),
  .Y_W     (Y_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_x_i     (req_x_i),
  .req_y_i     (req_y_i),
  .req_rid_i   (req_rid_i),
  .req_addr_i  (req_addr_i),
  .req_kind_i  (req_kind_i),
  .req_miss_i  (req_miss_i),
  .rsp_valid_o (rsp_valid_o),
  .dst_x_o     (dst_x_o),
  .dst_y_o     (dst_y_o),
  .remote_o    (remote_o)
);

// File: tb/test_rinl_bank_locator.sv
module test_rinl_bank_locator;
  localparam int ADDR_W  = 32;
  localparam int SEL_LSB = 12;
  localparam int MW      = 4;
  localparam int MH      = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              req_valid_i;
  logic [1:0]        req_x_i;
  logic [1:0]        req_y_i;
  logic [1:0]        req_rid_i;
  logic [ADDR_W-1:0] req_addr_i;
  logic [1:0]        req_kind_i;
  logic              req_miss_i;
  logic              rsp_valid_o;
  logic [1:0]        dst_x_o;
  logic [1:0]        dst_y_o;
  logic              remote_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int    exp_x = 0, exp_y = 0, exp_r = 0, exp_v = 0;
  string exp_tag = "R3";

  always #4 clk_i = ~clk_i;

  rinl_bank_locator #(
    .ADDR_W (ADDR_W), .SEL_LSB (SEL_LSB), .MESH_W (MW), .MESH_H (MH)
  ) i_rinl_bank_locator (
    .clk_i, .rst_ni, .req_valid_i, .req_x_i, .req_y_i, .req_rid_i,
    .req_addr_i, .req_kind_i, .req_miss_i,
    .rsp_valid_o, .dst_x_o, .dst_y_o, .remote_o
  );

  function automatic logic [ADDR_W-1:0] mk_addr(int sel, int hi, int junk);
    return ADDR_W'((junk & 32'hfff) | (sel << SEL_LSB) | (hi << (SEL_LSB + 2))
                   | ((junk >> 12) << (SEL_LSB + 4)));
  endfunction

  task automatic check_out();
    checks++;
    if (int'(rsp_valid_o) != exp_v) begin
      errors++;
      $display("FAIL R1 valid actual=%0d expected=%0d", rsp_valid_o, exp_v);
    end
    checks++;
    if (int'(dst_x_o) != exp_x || int'(dst_y_o) != exp_y || int'(remote_o) != exp_r) begin
      errors++;
      $display("FAIL %s dst actual=(%0d,%0d,r%0d) expected=(%0d,%0d,r%0d)",
               exp_tag, dst_x_o, dst_y_o, remote_o, exp_x, exp_y, exp_r);
    end
  endtask

  // drive just after a falling edge, check at the next falling edge
  task automatic step(bit v, int x, int y, int rid, logic [ADDR_W-1:0] a, int kind, bit miss);
    int sel, m, hx, hy;
    req_valid_i = v;
    req_x_i     = 2'(x);
    req_y_i     = 2'(y);
    req_rid_i   = 2'(rid);
    req_addr_i  = a;
    req_kind_i  = 2'(kind);
    req_miss_i  = miss;
    sel = int'((a >> SEL_LSB) & 3);
    hx  = int'((a >> SEL_LSB) & 3);
    hy  = int'((a >> (SEL_LSB + 2)) & 3);
    m   = (((rid - sel) % 4) + 4) % 4;
    exp_v = int'(v);
    if (!v) begin
      exp_tag = "R2";
    end else if (kind == 0 && miss) begin
      exp_x = hx; exp_y = hy; exp_r = 1; exp_tag = "R8";
    end else if (kind == 0) begin
      exp_r = 0;
      exp_x = x;  exp_y = y;
      case (m)
        0: exp_tag = "R4";
        3: begin exp_x = (x + 1) % MW;      exp_tag = "R5"; end
        1: begin exp_x = (x + MW - 1) % MW; exp_tag = "R6"; end
        default: begin exp_y = (y + 1) % MH; exp_tag = "R7"; end
      endcase
    end else if (kind == 1) begin
      exp_x = x; exp_y = y; exp_r = 0; exp_tag = "R9";
    end else begin
      exp_x = hx; exp_y = hy; exp_r = 0; exp_tag = "R10";
    end
    @(negedge clk_i);
    check_out();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    req_valid_i = 1'b0; req_x_i = '0; req_y_i = '0; req_rid_i = '0;
    req_addr_i = '0; req_kind_i = '0; req_miss_i = 1'b0;
    repeat (3) @(negedge clk_i);
    exp_tag = "R3";
    check_out();  // R3 reset values
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4..R7 directed, including edge wraps and the +-3 cases
    step(1, 1, 1, 2, mk_addr(2, 0, 5), 0, 0);   // R4 diff 0
    step(1, 3, 0, 1, mk_addr(2, 1, 7), 0, 0);   // R5 diff -1, wrap x 3->0
    step(1, 1, 2, 3, mk_addr(0, 2, 9), 0, 0);   // R5 diff +3
    step(1, 0, 1, 2, mk_addr(1, 3, 3), 0, 0);   // R6 diff +1, wrap x 0->3
    step(1, 2, 2, 0, mk_addr(3, 0, 1), 0, 0);   // R6 diff -3
    step(1, 2, 3, 3, mk_addr(1, 1, 2), 0, 0);   // R7 diff +2, wrap y 3->0
    step(1, 0, 0, 0, mk_addr(2, 3, 4), 0, 0);   // R7 diff -2
    // R2 hold across idle cycles with junk inputs
    step(0, 3, 3, 1, mk_addr(3, 3, 8), 2, 1);
    step(0, 1, 0, 0, mk_addr(0, 0, 6), 1, 0);
    // R8 fallback
    step(1, 1, 1, 1, mk_addr(1, 2, 11), 0, 1);
    step(1, 3, 3, 0, mk_addr(3, 3, 12), 0, 1);
    // R9 private, miss ignored
    step(1, 2, 1, 3, mk_addr(0, 3, 13), 1, 1);
    step(1, 0, 3, 1, mk_addr(2, 1, 14), 1, 0);
    // R10 shared and code 3, miss ignored
    step(1, 2, 2, 2, mk_addr(3, 1, 15), 2, 1);
    step(1, 1, 3, 0, mk_addr(1, 2, 16), 3, 0);
    step(1, 3, 0, 2, mk_addr(0, 3, 17), 2, 0);
    // R1 back to back idle
    step(0, 0, 0, 0, '0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      int x, y, k;
      x = int'($urandom_range(0, MW - 1));
      y = int'($urandom_range(0, MH - 1));
      k = int'($urandom_range(0, 3));
      step(($urandom_range(0, 3) != 0), x, y, (x + 2 * y) % 4,
           ADDR_W'($urandom), k, ($urandom_range(0, 2) == 0));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule